// File: doc/BRIEF.md
# Loopback UART Register File

This block presents the eight byte-wide registers of a 16550-compatible serial controller to a simple host bus, but has no serial line behind it. Every byte the host writes to the transmit holding register goes into a loopback FIFO, and reads of the receive buffer return those bytes oldest first. Software drivers written for a 16550 can therefore be brought up and exercised against it without a baud generator, a shifter or modem pins.

The divisor latch, FIFO control with four trigger levels, line status, modem status, interrupt enable, interrupt identification, line control, modem control and scratch registers are all present. Modem status and the interrupt sources come from FIFO occupancy and the modem control bits instead of from external pins. The interrupt output is a level that is high while any enabled condition is pending, and it is also held high for one cycle when one of a set of events occurs.

Register writes take effect on the clock edge where `wrEn` is high. `rdData` shows the addressed register combinationally. A read with side effects (popping the FIFO) happens on the edge where `rdEn` is high and `wrEn` is low.

Top module: `lbuart_regs`

## Requirements
- R1: While line control bit 7 is set, a write to offset 0 or 1 loads the low or high divisor byte and a read of offset 0 or 1 returns it. The FIFO is not touched. Any line control write with bit 7 set clears the divisor to 0.
- R2: With line control bit 7 clear, a write to offset 0 stores the byte in the FIFO when the FIFO has space, and it clears the overrun flag.
- R3: A write to offset 0 when the FIFO already holds its effective depth drops the byte and sets the overrun flag. The stored bytes and their order are unchanged. The overrun flag stays set until the next successful push.
- R4: With line control bit 7 clear, a read of offset 0 returns the oldest byte and removes it. On an empty FIFO it returns 0x00 and changes nothing.
- R5: A write to offset 2 (FIFO control) works as follows. Bits 7:6 pick the receive trigger level: 00→1, 01→4, 10→8, 11→14. Bit 1 or bit 2 empties the FIFO. With bit 0 clear, the effective depth is 1 and the trigger level is 1. With bit 0 set, the depth is 16.
- R6: With line control bit 7 clear, a read of offset 1 returns the interrupt enables in bits 3:0 and zeros in bits 7:4. The enable bits are: bit 0 receive data, bit 1 transmit-empty, bit 2 line status, bit 3 modem status.
- R7: A read of offset 2 returns 0xC6 for line status (enabled and overrun set), then 0xC4 for receive data (enabled and count at or above trigger), then 0xC2 for transmit-empty (enabled and FIFO empty), then 0xC0 for modem status (enabled and modem control bit 0 or 1 set). Only the highest pending source is reported, and 0xC1 is returned when none is pending.
- R8: A read of offset 5 returns bit 0 set when the FIFO holds data, bit 1 set while overrun is set, and bits 5 and 6 set when the FIFO is empty. All other bits are 0.
- R9: A read of offset 6 returns 0xB3 (carrier bit 7, data-set-ready bit 5 and its delta bit 1, clear-to-send bit 4 and its delta bit 0). When modem control bit 5 is set and the FIFO is full, it returns 0xA2.
- R10: `irq` is forced high for the one cycle after any of these events:
  - a push that makes the count equal the trigger level while receive-data is enabled;
  - a dropped write while line status is enabled;
  - an enable write with bit 1 set while the FIFO is empty;
  - a pop that empties the FIFO while transmit-empty is enabled;
  - a modem control write with bit 3, 1 or 0 set while modem status is enabled.
- R11: `irq` is high whenever the identification register would report a pending source.
- R12: Writes to offsets 3, 4 and 7 are stored verbatim and read back unchanged.
- R13: After reset the FIFO is empty and overrun, line control, modem control and the enables are 0. FIFO mode is enabled with trigger level 1, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (side effects on this edge) |
| rdData | output | 8 | Addressed register value (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench writes a seventeenth byte into a full FIFO. A design that wrapped its write pointer would corrupt the oldest byte, and this shows up in the pop order. It also forces several interrupt sources to be pending together, so an identification register built from ORed bits instead of a priority pick returns the wrong code. A modem control write that sets only bit 3 must give a single-cycle `irq` pulse while the identification register stays idle. A design that kept the pulse as a level, or lost it, fails at that cycle. Finally, the divisor latch is loaded with line control bit 7 set. A decoder that ignored that bit would push those bytes into the FIFO, and line status would then report data.

// File: rtl/lbuart_pkg.sv
package lbuart_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_FCTL = 3'd2;
  localparam logic [2:0] OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_MCTL = 3'd4;
  localparam logic [2:0] OFS_LSTS = 3'd5;
  localparam logic [2:0] OFS_MSTS = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam logic [7:0] ID_NONE = 8'hC1;
  localparam logic [7:0] ID_LINE = 8'hC6;
  localparam logic [7:0] ID_RXD  = 8'hC4;
  localparam logic [7:0] ID_TXE  = 8'hC2;
  localparam logic [7:0] ID_MDM  = 8'hC0;

  localparam logic [7:0] MSTS_BASE = 8'hA2;
  localparam logic [7:0] MSTS_CTS  = 8'h11;

  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } fifoStrobe_t;
endpackage

// File: rtl/lbuart_fifo.sv
module lbuart_fifo
  import lbuart_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   stb,
  input  logic [7:0]    pushData,
  output logic [7:0]    headData,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) begin
        wrPtr <= nextPtr(wrPtr);
        count <= count + CW'(1);
      end else if (stb.pop) begin
        rdPtr <= nextPtr(rdPtr);
        count <= count - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push && !stb.clr) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/lbuart_ctrl.sv
module lbuart_ctrl
  import lbuart_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    addr,
  input  logic          wrEn,
  input  logic [7:0]    wrData,
  input  logic          rdEn,
  input  logic [CW-1:0] count,
  input  logic [7:0]    headData,
  output fifoStrobe_t   stb,
  output logic [7:0]    rdData,
  output logic          irq,
  output logic          dlab,
  output logic          fifoEn
);
  logic [3:0]    ienReg;
  logic [7:0]    lctlReg, mctlReg, scrReg;
  logic [15:0]   divisor;
  logic          overrun;
  logic [CW-1:0] trigLvl;
  logic          evtQ;

  logic [CW-1:0] depthEff;
  logic          full, empty, dataWr, ovf, rdAct;
  logic          pLine, pRxd, pTxe, pMdm;
  logic          evRxd, evLine, evTxe, evPop, evMdm;
  logic [7:0]    idVal, lsts, msts;
  logic [CW-1:0] newTrig;

  assign dlab     = lctlReg[7];
  assign depthEff = fifoEn ? CW'(DEPTH) : CW'(1);
  assign full     = count >= depthEff;
  assign empty    = (count == '0);
  assign dataWr   = wrEn && addr == OFS_DATA && !dlab;
  assign ovf      = dataWr && full;
  assign rdAct    = rdEn && !wrEn;

  always_comb begin
    stb.push = dataWr && !full;
    stb.pop  = rdAct && addr == OFS_DATA && !dlab && !empty;
    stb.clr  = wrEn && addr == OFS_FCTL && (wrData[1] || wrData[2]);
  end

  always_comb begin
    case (wrData[7:6])
      2'b00:   newTrig = CW'(1);
      2'b01:   newTrig = CW'(4);
      2'b10:   newTrig = CW'(8);
      default: newTrig = CW'(14);
    endcase
  end

  // pending sources, priority order
  assign pLine = ienReg[2] && overrun;
  assign pRxd  = ienReg[0] && (count >= trigLvl);
  assign pTxe  = ienReg[1] && empty;
  assign pMdm  = ienReg[3] && (mctlReg[1] || mctlReg[0]);

  always_comb begin
    if (pLine)     idVal = ID_LINE;
    else if (pRxd) idVal = ID_RXD;
    else if (pTxe) idVal = ID_TXE;
    else if (pMdm) idVal = ID_MDM;
    else           idVal = ID_NONE;
  end

  // one-shot events
  assign evRxd  = stb.push && ienReg[0] && ((count + CW'(1)) == trigLvl);
  assign evLine = ovf && ienReg[2];
  assign evTxe  = wrEn && addr == OFS_IEN && !dlab && wrData[1] && empty;
  assign evPop  = stb.pop && ienReg[1] && (count == CW'(1));
  assign evMdm  = wrEn && addr == OFS_MCTL && ienReg[3] &&
                  (wrData[3] || wrData[1] || wrData[0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienReg  <= '0;
      lctlReg <= '0;
      mctlReg <= '0;
      scrReg  <= '0;
      divisor <= '0;
      overrun <= 1'b0;
      trigLvl <= CW'(1);
      fifoEn  <= 1'b1;
      evtQ    <= 1'b0;
    end else begin
      evtQ <= evRxd || evLine || evTxe || evPop || evMdm;
      if (stb.push) overrun <= 1'b0;
      else if (ovf) overrun <= 1'b1;
      if (wrEn) begin
        case (addr)
          OFS_DATA: if (dlab) divisor[7:0] <= wrData;
          OFS_IEN: begin
            if (dlab) divisor[15:8] <= wrData;
            else      ienReg <= wrData[3:0];
          end
          OFS_FCTL: begin
            fifoEn  <= wrData[0];
            trigLvl <= wrData[0] ? newTrig : CW'(1);
          end
          OFS_LCTL: begin
            lctlReg <= wrData;
            if (wrData[7]) divisor <= '0;
          end
          OFS_MCTL: mctlReg <= wrData;
          OFS_SCR:  scrReg  <= wrData;
          default: ;
        endcase
      end
    end
  end

  assign lsts = {1'b0, empty, empty, 3'b000, overrun, !empty};
  assign msts = MSTS_BASE | ((!mctlReg[5] || !full) ? MSTS_CTS : 8'h00);

  always_comb begin
    case (addr)
      OFS_DATA: rdData = dlab ? divisor[7:0] : (empty ? 8'h00 : headData);
      OFS_IEN:  rdData = dlab ? divisor[15:8] : {4'b0000, ienReg};
      OFS_FCTL: rdData = idVal;
      OFS_LCTL: rdData = lctlReg;
      OFS_MCTL: rdData = mctlReg;
      OFS_LSTS: rdData = lsts;
      OFS_MSTS: rdData = msts;
      default:  rdData = scrReg;
    endcase
  end

  assign irq = evtQ || (idVal != ID_NONE);
endmodule

// File: rtl/lbuart_regs.sv
module lbuart_regs
  import lbuart_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData,
  output logic       irq
);
  fifoStrobe_t   stb;
  logic [CW-1:0] fifoCount;
  logic [7:0]    headData;
  logic          dlab, fifoEn;

  lbuart_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .count(fifoCount), .headData(headData), .stb(stb),
    .rdData(rdData), .irq(irq), .dlab(dlab), .fifoEn(fifoEn)
  );

  lbuart_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .stb(stb), .pushData(wrData),
    .headData(headData), .count(fifoCount)
  );
endmodule

// File: rtl/lbuart_chk.sv
module lbuart_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [2:0]    addr,
  input logic          wrEn,
  input logic [7:0]    rdData,
  input logic          irq,
  input logic [CW-1:0] count,
  input logic          dlab,
  input logic          fifoEn,
  input logic          pushStb
);
  // R3: storage never exceeds the physical depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R3: a data write into a full 16-deep FIFO leaves the count at the top
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0 && !dlab && fifoEn && count == CW'(DEPTH))
      |=> (count == CW'(DEPTH)));

  // R2: an accepted push grows the count by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (pushStb && !(wrEn && addr == 3'd2)) |=> (count == $past(count) + CW'(1)));

  // R11: any pending identification code drives the request line
  a_r11_pending_irq: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd2 && !rdData[0]) |-> irq);

  // R8: data-ready and transmit-empty are mutually exclusive
  a_r8_lsts_excl: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd5) |-> (rdData[0] != rdData[5]));

  // R6: enable readback has its upper nibble clear
  a_r6_ien_nibble: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd1 && !dlab) |-> (rdData[7:4] == 4'h0));
endmodule

bind lbuart_regs lbuart_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdData(rdData),
  .irq(irq), .count(fifoCount), .dlab(dlab), .fifoEn(fifoEn),
  .pushStb(stb.push)
);

// File: tb/sim_lbuart_regs.sv
`timescale 1ns/100ps
module sim_lbuart_regs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lbuart_regs u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
    #1;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(5, v); check("R13 lsts", v, 8'h60);
    peek(2, v); check("R13 id", v, 8'hC1);
    peek(1, v); check("R13 ien", v, 8'h00);
    peek(3, v); check("R13 lctl", v, 8'h00);
    peek(6, v); check("R13 msts", v, 8'hB3);
    check("R13 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_plain;
    logic [7:0] v;
    wr(3, 8'h1B); peek(3, v); check("R12 lctl", v, 8'h1B);
    wr(7, 8'h5A); peek(7, v); check("R12 scratch", v, 8'h5A);
    wr(4, 8'h20); peek(4, v); check("R12 mctl", v, 8'h20);
    wr(4, 8'h00);
  endtask

  task automatic t_divisor;
    logic [7:0] v;
    wr(3, 8'h80);
    wr(0, 8'h34); wr(1, 8'h12);
    rd(0, v); check("R1 div lo", v, 8'h34);
    rd(1, v); check("R1 div hi", v, 8'h12);
    peek(5, v); check("R1 fifo untouched", v, 8'h60);
    wr(3, 8'h83);
    peek(0, v); check("R1 clear lo", v, 8'h00);
    peek(1, v); check("R1 clear hi", v, 8'h00);
    wr(3, 8'h03);
  endtask

  task automatic t_order;
    logic [7:0] v;
    wr(0, 8'h11); wr(0, 8'h22); wr(0, 8'h33);
    peek(5, v); check("R8 lsts data", v, 8'h01);
    rd(0, v); check("R4 pop1", v, 8'h11);
    rd(0, v); check("R4 pop2", v, 8'h22);
    rd(0, v); check("R2 pop3", v, 8'h33);
    rd(0, v); check("R4 empty read", v, 8'h00);
    peek(5, v); check("R4 lsts empty", v, 8'h60);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    for (int i = 0; i < 17; i++) wr(0, 8'h40 + 8'(i));
    peek(5, v); check("R3 lsts overrun", v, 8'h03);
    peek(6, v); check("R9 msts no autoflow", v, 8'hB3);
    wr(4, 8'h20);
    peek(6, v); check("R9 msts full", v, 8'hA2);
    rd(0, v); check("R3 oldest kept", v, 8'h40);
    peek(6, v); check("R9 msts space", v, 8'hB3);
    wr(4, 8'h00);
    for (int i = 1; i < 16; i++) begin
      rd(0, v); check("R3 order", v, 8'h40 + 8'(i));
    end
    peek(5, v); check("R3 overrun sticky", v, 8'h62);
    wr(0, 8'h77);
    peek(5, v); check("R2 overrun cleared", v, 8'h01);
    rd(0, v); check("R2 data", v, 8'h77);
  endtask

  task automatic t_trigger;
    logic [7:0] v;
    wr(1, 8'h01);
    wr(2, 8'h41);
    for (int i = 0; i < 3; i++) wr(0, 8'(i));
    peek(2, v); check("R5 below trig4", v, 8'hC1);
    check("R11 irq low", {7'd0, irq}, 8'h00);
    wr(0, 8'h03);
    check("R11 irq at trig4", {7'd0, irq}, 8'h01);
    peek(2, v); check("R5 trig4", v, 8'hC4);
    wr(2, 8'hC7);
    peek(5, v); check("R5 clear", v, 8'h60);
    for (int i = 0; i < 13; i++) wr(0, 8'(i));
    peek(2, v); check("R5 below trig14", v, 8'hC1);
    wr(0, 8'h0D);
    peek(2, v); check("R5 trig14", v, 8'hC4);
    wr(2, 8'h07);
    wr(1, 8'h00);
  endtask

  task automatic t_depth1;
    logic [7:0] v;
    wr(2, 8'h06);
    wr(0, 8'hAA); wr(0, 8'hBB);
    peek(5, v); check("R5 depth1 overrun", v, 8'h03);
    wr(1, 8'h01);
    peek(2, v); check("R7 rxd", v, 8'hC4);
    wr(1, 8'h05);
    peek(2, v); check("R7 line over rxd", v, 8'hC6);
    rd(0, v); check("R5 depth1 data", v, 8'hAA);
    peek(5, v); check("R8 empty overrun", v, 8'h62);
    wr(1, 8'h00);
    wr(2, 8'h07);
    wr(0, 8'h00);
    rd(0, v);
  endtask

  task automatic t_ien;
    logic [7:0] v;
    wr(1, 8'hF0); peek(1, v); check("R6 upper ignored", v, 8'h00);
    wr(1, 8'h09); peek(1, v); check("R6 readback", v, 8'h09);
    wr(1, 8'h00);
  endtask

  task automatic t_priority;
    logic [7:0] v;
    wr(1, 8'h0A); wr(4, 8'h03);
    peek(2, v); check("R7 txe over mdm", v, 8'hC2);
    wr(0, 8'h55);
    peek(2, v); check("R7 mdm", v, 8'hC0);
    wr(1, 8'h0B);
    peek(2, v); check("R7 rxd over mdm", v, 8'hC4);
    rd(0, v);
    peek(2, v); check("R7 txe again", v, 8'hC2);
    wr(1, 8'h00); wr(4, 8'h00);
  endtask

  task automatic t_pulse;
    logic [7:0] v;
    wr(1, 8'h08);
    check("R10 idle", {7'd0, irq}, 8'h00);
    wr(4, 8'h08);
    check("R10 pulse", {7'd0, irq}, 8'h01);
    @(negedge clk); #1;
    check("R10 pulse ends", {7'd0, irq}, 8'h00);
    peek(2, v); check("R10 nothing pending", v, 8'hC1);
    wr(1, 8'h00); wr(4, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_plain();
    t_divisor();
    t_order();
    t_overflow();
    t_trigger();
    t_depth1();
    t_ien();
    t_priority();
    t_pulse();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule